// File: doc/BRIEF.md
# Push-Button Serial Character Transmitter

This block sends one character over an asynchronous serial line each time an operator presses a push-button. A bank of switches supplies the character. The button and the switches come straight from the board, so the block brings both into the system clock domain with two-stage synchronisers. A falling-edge detector then turns each press into a single one-cycle start request.

The frame starts with a low start bit. The data bits follow, least significant first, then a parity bit and a high stop bit. The line rests high between frames. Build parameters set the system clock frequency, the line rate, the data width (7 or 8 bits) and the parity sense (odd or even). A baud counter paces every bit, and it runs only while a frame is in flight.

There is no stream handshake at the edge. The press is the request. `tx_busy` is the only back-pressure signal, and the block keeps no queue. A press that arrives while a frame is on the line is dropped, and the operator has to press again.

Top module: `kp_uart_tx`

## Requirements
- R1: After synchronous reset, and whenever no frame is being sent, `tx_line` is 1 and `tx_busy` is 0.
- R2: The start bit (`tx_line` = 0) and `tx_busy` = 1 appear on the third rising clock edge after `send_btn_n` falls. The chain is two synchroniser stages and then the edge register.
- R3: Every frame bit lasts exactly DIV = round(CLK_HZ / BAUD) clock cycles. BAUD must be 9600, 19200, 38400 or 57600.
- R4: Bits 1..DATA_BITS of the frame carry the data word, bit 0 of the word first. DATA_BITS is 7 or 8.
- R5: The frame bit after the data is the parity bit. With ODD_PARITY = 1, the total count of ones in the data and parity bits is odd. With ODD_PARITY = 0, it is even.
- R6: The last frame bit is a stop bit at 1. `tx_busy` stays high from the start bit to the end of the stop bit, which is exactly (DATA_BITS + 3) × DIV cycles.
- R7: A held button sends one frame only. No further frame starts until the button is released and pressed again.
- R8: A press that arrives while `tx_busy` is high is ignored. The frame in progress keeps its length, and no second frame follows it.
- R9: The data word is captured when the frame starts. Switch changes during the frame do not alter the bits sent.
- R10: Asserting `rst` in the middle of a frame returns the line to idle (`tx_line` = 1, `tx_busy` = 0) on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every flip-flop uses it |
| rst | input | 1 | Synchronous reset, active high |
| sw_data | input | DATA_BITS | Asynchronous data switches |
| send_btn_n | input | 1 | Asynchronous send button, active low |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | High while a frame is on the line |

## Verification
The bench builds two instances. The first sends 8-bit odd-parity frames at 38400 baud with a 460.8 kHz system clock, giving 12 cycles per bit. The second sends 7-bit even-parity frames at 9600 baud with a 96 kHz clock, giving 10 cycles per bit. Together they cover both data widths, both parity senses and two divisor values. Short frames let the bench sample the middle of every bit of many random words. Within the same run it also presses during a frame, changes the switches mid-frame, holds the button down and resets in the middle of a frame.

// File: rtl/kp_uart_pkg.sv
package kp_uart_pkg;

  // Rounded clock-to-bit divisor.
  function automatic int baud_divisor(input int clk_hz, input int baud);
    return (clk_hz + baud / 2) / baud;
  endfunction

  function automatic bit baud_supported(input int baud);
    return (baud == 9600) || (baud == 19200) || (baud == 38400) || (baud == 57600);
  endfunction

  // Parity bit that makes the data+parity ones count odd (odd=1) or even (odd=0).
  function automatic logic parity_bit(input logic [7:0] word, input int nbits, input bit odd);
    logic p;
    p = odd;
    for (int i = 0; i < 8; i++) begin
      if (i < nbits) p = p ^ word[i];
    end
    return p;
  endfunction

endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RST_VAL;
    else     stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= RST_VAL;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/kp_baud_tick.sv
module kp_baud_tick #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(DIV) + 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/kp_frame_tx.sv
module kp_frame_tx
  import kp_uart_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter bit ODD_PARITY = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 tick,
  input  logic [DATA_BITS-1:0] data,
  output logic                 tx,
  output logic                 busy
);
  localparam int FB = DATA_BITS + 3;
  localparam int BW = $clog2(FB);
  localparam logic [BW-1:0] LAST_BIT = BW'(FB - 1);

  logic [FB-1:0] shreg_q;
  logic [BW-1:0] bitn_q;
  logic          par;

  assign par = parity_bit(8'(data), DATA_BITS, ODD_PARITY);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '1;
      bitn_q  <= '0;
      busy    <= 1'b0;
      tx      <= 1'b1;
    end else if (!busy) begin
      if (start) begin
        shreg_q <= {1'b1, par, data, 1'b0};
        bitn_q  <= '0;
        busy    <= 1'b1;
        tx      <= 1'b0;
      end
    end else if (tick) begin
      if (bitn_q == LAST_BIT) begin
        busy <= 1'b0;
        tx   <= 1'b1;
      end else begin
        shreg_q <= {1'b1, shreg_q[FB-1:1]};
        tx      <= shreg_q[1];
        bitn_q  <= bitn_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kp_uart_tx.sv
module kp_uart_tx
  import kp_uart_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BAUD       = 9600,
  parameter int DATA_BITS  = 8,
  parameter bit ODD_PARITY = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_BITS-1:0] sw_data,
  input  logic                 send_btn_n,
  output logic                 tx_line,
  output logic                 tx_busy
);
  localparam int DIV       = baud_divisor(CLK_HZ, BAUD);
  localparam int FRAME_CYC = (DATA_BITS + 3) * DIV;

  if (!baud_supported(BAUD)) begin : g_bad_baud
    $error("kp_uart_tx: unsupported line rate");
  end
  if (DATA_BITS != 7 && DATA_BITS != 8) begin : g_bad_width
    $error("kp_uart_tx: data width must be 7 or 8");
  end

  logic                 btn_s;
  logic                 btn_prev_q;
  logic                 press_pulse;
  logic [DATA_BITS-1:0] sw_s;
  logic                 baud_tick;

  kp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_btn_sync (
    .clk(clk), .rst(rst), .din(send_btn_n), .dout(btn_s)
  );

  kp_sync #(.W(DATA_BITS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sw_sync (
    .clk(clk), .rst(rst), .din(sw_data), .dout(sw_s)
  );

  always_ff @(posedge clk) begin
    if (rst) btn_prev_q <= 1'b1;
    else     btn_prev_q <= btn_s;
  end

  assign press_pulse = btn_prev_q & ~btn_s;

  kp_baud_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .run(tx_busy), .tick(baud_tick)
  );

  kp_frame_tx #(.DATA_BITS(DATA_BITS), .ODD_PARITY(ODD_PARITY)) u_frame (
    .clk(clk), .rst(rst), .start(press_pulse), .tick(baud_tick),
    .data(sw_s), .tx(tx_line), .busy(tx_busy)
  );
endmodule

// File: rtl/kp_uart_tx_chk.sv
module kp_uart_tx_chk #(
  parameter int FRAME_CYC = 1
) (
  input logic clk,
  input logic rst,
  input logic tx,
  input logic busy,
  input logic press
);
  int unsigned busy_cyc;

  always_ff @(posedge clk) begin
    if (rst)       busy_cyc <= 0;
    else if (busy) busy_cyc <= busy_cyc + 1;
    else           busy_cyc <= 0;
  end

  p_idle_line_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx);

  p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (press && !busy) |=> (busy && !tx));

  p_frame_len_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> (busy_cyc == FRAME_CYC));

  p_stop_bit_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> $past(tx));

  p_press_only_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(press));
endmodule

bind kp_uart_tx kp_uart_tx_chk #(.FRAME_CYC(FRAME_CYC)) u_chk (
  .clk(clk), .rst(rst), .tx(tx_line), .busy(tx_busy), .press(press_pulse)
);

// File: tb/sim_kp_uart_tx.sv
module sim_kp_uart_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sw0 = '0;
  logic [6:0] sw1 = '0;
  logic       btn0 = 1'b1, btn1 = 1'b1;
  logic       tx0, busy0, tx1, busy1;
  int         checks = 0, fails = 0;
  int         cyc = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  kp_uart_tx #(.CLK_HZ(460_800), .BAUD(38400), .DATA_BITS(8), .ODD_PARITY(1'b1)) u0 (
    .clk(clk), .rst(rst), .sw_data(sw0), .send_btn_n(btn0), .tx_line(tx0), .tx_busy(busy0)
  );
  kp_uart_tx #(.CLK_HZ(96_000), .BAUD(9600), .DATA_BITS(7), .ODD_PARITY(1'b0)) u1 (
    .clk(clk), .rst(rst), .sw_data(sw1), .send_btn_n(btn1), .tx_line(tx1), .tx_busy(busy1)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input logic [7:0] w, input int nb, input bit odd, input int k);
    logic p;
    if (k == 0) return 1'b0;
    if (k <= nb) return w[k-1];
    if (k == nb + 1) begin
      p = odd;
      for (int i = 0; i < nb; i++) p = p ^ w[i];
      return p;
    end
    return 1'b1;
  endfunction

  function automatic logic cur_tx(input int which);
    return which ? tx1 : tx0;
  endfunction
  function automatic logic cur_busy(input int which);
    return which ? busy1 : busy0;
  endfunction

  task automatic set_btn(input int which, input logic v);
    if (which) btn1 = v; else btn0 = v;
  endtask
  task automatic set_sw(input int which, input logic [7:0] v);
    if (which) sw1 = v[6:0]; else sw0 = v;
  endtask

  // Sends one frame and checks every bit at its centre.
  task automatic send_frame(input int which, input logic [7:0] word, input bit disturb);
    int div = which ? 10 : 12;
    int nb  = which ? 7 : 8;
    bit odd = which ? 1'b0 : 1'b1;
    int fb  = nb + 3;
    int bad = 0;
    @(negedge clk); set_sw(which, word);
    repeat (4) @(negedge clk);
    set_btn(which, 1'b0);
    @(negedge clk);
    @(negedge clk);
    check(cur_tx(which) == 1'b1, "R2 line still idle after two edges", cur_tx(which), 1);
    @(negedge clk);
    check(cur_tx(which) == 1'b0 && cur_busy(which), "R2 start bit on third edge",
          {cur_busy(which), cur_tx(which)}, 2);
    repeat (div / 2) @(negedge clk);
    check(cur_tx(which) == 1'b0, "R3 start bit lasts a full bit time", cur_tx(which), 0);
    for (int k = 1; k < fb; k++) begin
      repeat (div) @(negedge clk);
      if (disturb && k == 2) begin
        set_sw(which, ~word);
        set_btn(which, 1'b1);
      end
      if (disturb && k == 4) set_btn(which, 1'b0);
      if (k <= nb)
        check(cur_tx(which) == exp_bit(word, nb, odd, k), disturb ? "R9 data bit after switch change" : "R4 data bit",
              cur_tx(which), exp_bit(word, nb, odd, k));
      else if (k == nb + 1)
        check(cur_tx(which) == exp_bit(word, nb, odd, k), "R5 parity bit", cur_tx(which), exp_bit(word, nb, odd, k));
      else
        check(cur_tx(which) == 1'b1 && cur_busy(which), "R6 stop bit high while busy",
              {cur_busy(which), cur_tx(which)}, 3);
    end
    repeat (div - div / 2 - 1) @(negedge clk);
    check(cur_busy(which) == 1'b1, "R6 busy through last stop cycle", cur_busy(which), 1);
    @(negedge clk);
    check(cur_busy(which) == 1'b0 && cur_tx(which), "R6 busy drops at frame end",
          {cur_busy(which), cur_tx(which)}, 1);
    for (int i = 0; i < 3 * div; i++) begin
      @(negedge clk);
      if (cur_busy(which) || !cur_tx(which)) bad++;
    end
    check(bad == 0, disturb ? "R8 press during frame ignored" : "R7 held button sends once", bad, 0);
    set_btn(which, 1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150_000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150_000);
      report();
      $finish;
    end
  end

  initial begin
    int bad;
    void'($urandom(32'h1d5e_ed01));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx0 && !busy0 && tx1 && !busy1, "R1 idle after reset", {busy0, tx0, busy1, tx1}, 5);

    send_frame(0, 8'h41, 1'b0);
    send_frame(0, 8'h00, 1'b0);
    send_frame(0, 8'hFF, 1'b1);
    send_frame(1, 8'h7F, 1'b0);
    send_frame(1, 8'h00, 1'b1);
    send_frame(1, 8'h2A, 1'b0);

    for (int i = 0; i < 16; i++) begin
      logic [7:0] w = 8'($urandom);
      send_frame(i % 2, w, ($urandom % 3) == 0);
    end

    // R10: reset in the middle of a frame
    @(negedge clk); sw0 = 8'h55;
    repeat (4) @(negedge clk);
    btn0 = 1'b0;
    repeat (30) @(negedge clk);
    check(busy0 == 1'b1, "R10 frame running before reset", busy0, 1);
    btn0 = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(tx0 && !busy0, "R10 idle right after reset", {busy0, tx0}, 1);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy0 || !tx0) bad++;
    end
    check(bad == 0, "R1 line stays idle after mid-frame reset", bad, 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule